// File: doc/BRIEF.md
# Phase Interpolator Strength Calibration Controller

This block is the digital side of a fine-delay interpolator that sits between two neighbouring coarse phases of a delay-locked line. The coarse line gives eight phases per reference period. The interpolator splits each coarse gap into sixteen fine steps by switching capacitive legs onto a mixing node. For sixteen legs to add up to exactly one coarse gap, the resistance that drives the node has to be trimmed. This controller does that trimming. It does not change the capacitance.

In calibration mode the controller enables every leg of load A and no leg of load B. The leading coarse phase feeds load A and the following phase feeds load B. At fixed intervals the controller reads a phase detector's late/early decision and moves a pull-up/pull-down resistor strength pair by one resistor per comparison. When the detector's decision has reversed on two comparisons in a row, the skew is taken as zero. The controller then freezes the code and raises a done flag. In interpolation mode load A is cleared and load B gets a thermometer enable of the requested fine setting.

Top module: `interp_cal_ctrl`

## Requirements
- R1: While reset is asserted, both strength codes read 16, `cal_done` is 0 and both leg-enable buses are all zeros.
- R2: One rising edge after `cal_mode` is sampled high, `load_a_en` is all ones and `load_b_en` is all zeros.
- R3: One rising edge after `cal_mode` is sampled low with fine request n (0 to 15), `load_a_en` is zero and `load_b_en` has exactly bits 0 to n-1 set, where bit i is leg i.
- R4: A calibration starts only from idle, on an edge that samples `cal_mode` high. That same edge clears `cal_done` and reloads both codes to 16.
- R5: With SETTLE = 3, the first detector comparison happens on the 4th rising edge after the start edge, and each later one 4 edges after the previous one. Codes change only on comparison edges.
- R6: Total strength t = `rup_code` + `rdn_code` always satisfies `rup_code` = ceil(t/2) and `rdn_code` = floor(t/2). A comparison with `det_late` = 1 raises t by one; one with `det_late` = 0 lowers t by one.
- R7: t saturates at 62 (both codes 31) and at 0 (both codes 0). A step past either limit leaves the codes unchanged.
- R8: A comparison whose decision differs from the previous comparison's decision counts as a reversal. A comparison that agrees clears the count. The comparison that makes the second reversal in a row applies no step, sets `cal_done` and locks.
- R9: While locked with `cal_mode` high, the codes and `cal_done` hold regardless of `det_late`.
- R10: Dropping `cal_mode` during calibration aborts to idle with `cal_done` 0 and the codes kept. Dropping it while locked returns to idle with `cal_done` still 1 and the codes kept.
- R11: `det_late` has no effect on any edge that is not a comparison edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_mode | input | 1 | 1 = calibration configuration, 0 = interpolation |
| det_late | input | 1 | Phase detector decision: 1 = interpolated edge late, raise strength |
| fine_req | input | 4 | Requested fine step within the coarse gap |
| rup_code | output | 5 | Pull-up resistor strength code |
| rdn_code | output | 5 | Pull-down resistor strength code |
| load_a_en | output | 16 | Leg enables of load A (leading phase) |
| load_b_en | output | 16 | Leg enables of load B (trailing phase) |
| cal_done | output | 1 | Calibration locked |

## Verification
Each leg-enable result is due on the first rising edge that samples the mode and fine inputs. Code updates and the done flag are due exactly on comparison edges: the fourth edge after a start, then every fourth edge. The bench model advances one step per rising edge from the same sampled inputs. It compares every output 1 ns after that edge, so each result is checked in the cycle it becomes due and never earlier. The detector input is left toggling between comparison edges, so a result that arrives early or late shows up as a mismatch on that cycle.

// File: rtl/interp_cal_pkg.sv
package interp_cal_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CAL  = 2'd1,
      ST_LOCK = 2'd2
   } cal_state_t;
endpackage

// File: rtl/icc_leg_drive.sv
module icc_leg_drive #(
   parameter int LEGS   = 16,
   parameter int FINE_W = $clog2(LEGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cal_mode,
   input  logic [FINE_W-1:0] fine_req,
   output logic [LEGS-1:0]   load_a_en,
   output logic [LEGS-1:0]   load_b_en
);
   logic [LEGS-1:0] a_nxt, b_nxt, a_q, b_q;

   // thermometer decode: leg i on when request exceeds i
   for (genvar i = 0; i < LEGS; i++) begin : g_leg
      localparam logic [FINE_W-1:0] IDX = FINE_W'(i);
      assign b_nxt[i] = !cal_mode && (fine_req > IDX);
      assign a_nxt[i] = cal_mode;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else begin
         a_q <= a_nxt;
         b_q <= b_nxt;
      end
   end

   assign load_a_en = a_q;
   assign load_b_en = b_q;

   assert_cal_legs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cal_mode |=> (&a_q && b_q == '0));
   assert_interp_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cal_mode |=> (a_q == '0 && $countones(b_q) == int'($past(fine_req))));
   assert_interp_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((b_q & (b_q + 1'b1)) == '0));
endmodule

// File: rtl/icc_seq.sv
module icc_seq
   import interp_cal_pkg::*;
#(
   parameter int SETTLE = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cal_mode,
   input  logic det_late,
   output logic load_mid,
   output logic step_en,
   output logic step_up,
   output logic done
);
   cal_state_t st;
   logic done_q, prev_q, have_q, tog_q;
   logic cmp_now, reversal, lock_now, start;

   assign start    = (st == ST_IDLE) && cal_mode;
   assign reversal = have_q && (det_late != prev_q);
   assign lock_now = (st == ST_CAL) && cal_mode && cmp_now && reversal && tog_q;

   // settle spacing between comparisons: counter only when a gap is asked for
   if (SETTLE > 0) begin : g_settle
      localparam int CNT_W = $clog2(SETTLE + 1);
      localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SETTLE);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        cnt_q <= '0;
         else if (start)                    cnt_q <= RELOAD;
         else if (st == ST_CAL && cal_mode) cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
      end
      assign cmp_now = (cnt_q == '0);
   end else begin : g_nosettle
      assign cmp_now = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         done_q <= 1'b0;
         prev_q <= 1'b0;
         have_q <= 1'b0;
         tog_q  <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (cal_mode) begin
               st     <= ST_CAL;
               done_q <= 1'b0;
               have_q <= 1'b0;
               tog_q  <= 1'b0;
            end
            ST_CAL: if (!cal_mode) begin
               st <= ST_IDLE;
            end else if (cmp_now) begin
               prev_q <= det_late;
               have_q <= 1'b1;
               if (reversal && tog_q) begin
                  st     <= ST_LOCK;
                  done_q <= 1'b1;
                  tog_q  <= 1'b0;
               end else begin
                  tog_q  <= reversal;
               end
            end
            ST_LOCK: if (!cal_mode) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign load_mid = start;
   assign step_en  = (st == ST_CAL) && cal_mode && cmp_now && !lock_now;
   assign step_up  = det_late;
   assign done     = done_q;

   assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && cal_mode) |=> (st == ST_CAL && !done_q));
   assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CAL && !cal_mode) |=> (st == ST_IDLE && !done_q));
   assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LOCK && cal_mode) |=> (st == ST_LOCK && done_q));
   assert_done_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> (st == ST_LOCK && $past(st == ST_CAL)));
endmodule

// File: rtl/icc_strength.sv
module icc_strength #(
   parameter int STR_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_mid,
   input  logic             step_en,
   input  logic             step_up,
   output logic [STR_W-1:0] rup,
   output logic [STR_W-1:0] rdn
);
   localparam logic [STR_W-1:0] MAXV = {STR_W{1'b1}};
   localparam logic [STR_W-1:0] MIDV = STR_W'(1 << (STR_W - 1));

   logic [STR_W-1:0] rup_q, rdn_q;
   logic [STR_W:0]   sum;
   logic             can_up, can_dn;

   // rup leads by at most one: rdn at max means both at max, rup at zero means both zero
   assign can_up = (rdn_q != MAXV);
   assign can_dn = (rup_q != '0);
   assign sum    = {1'b0, rup_q} + {1'b0, rdn_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rup_q <= MIDV;
         rdn_q <= MIDV;
      end else if (load_mid) begin
         rup_q <= MIDV;
         rdn_q <= MIDV;
      end else if (step_en) begin
         if (step_up && can_up) begin
            if (rup_q == rdn_q) rup_q <= rup_q + 1'b1;
            else                rdn_q <= rdn_q + 1'b1;
         end else if (!step_up && can_dn) begin
            if (rup_q != rdn_q) rup_q <= rup_q - 1'b1;
            else                rdn_q <= rdn_q - 1'b1;
         end
      end
   end

   assign rup = rup_q;
   assign rdn = rdn_q;

   assert_pair_balance_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rup_q == rdn_q) || (rup_q == rdn_q + 1'b1));
   assert_step_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !load_mid && step_up && can_up) |=> (sum == $past(sum) + 1'b1));
   assert_step_dn_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !load_mid && !step_up && can_dn) |=> (sum == $past(sum) - 1'b1));
   assert_sat_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !load_mid && step_up && !can_up) |=> (rup_q == MAXV && rdn_q == MAXV));
   assert_sat_bot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !load_mid && !step_up && !can_dn) |=> (rup_q == '0 && rdn_q == '0));
endmodule

// File: rtl/interp_cal_ctrl.sv
module interp_cal_ctrl #(
   parameter int LEGS   = 16,
   parameter int STR_W  = 5,
   parameter int SETTLE = 3,
   localparam int FINE_W = $clog2(LEGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cal_mode,
   input  logic              det_late,
   input  logic [FINE_W-1:0] fine_req,
   output logic [STR_W-1:0]  rup_code,
   output logic [STR_W-1:0]  rdn_code,
   output logic [LEGS-1:0]   load_a_en,
   output logic [LEGS-1:0]   load_b_en,
   output logic              cal_done
);
   if (LEGS < 2 || (LEGS & (LEGS - 1)) != 0) begin : g_bad_legs
      $error("LEGS must be a power of two of at least 2");
   end
   if (STR_W < 2) begin : g_bad_strw
      $error("STR_W must be at least 2");
   end
   if (SETTLE < 0) begin : g_bad_settle
      $error("SETTLE must not be negative");
   end

   logic load_mid, step_en, step_up;

   icc_seq #(.SETTLE(SETTLE)) u_seq (
      .clk(clk), .rst_n(rst_n), .cal_mode(cal_mode), .det_late(det_late),
      .load_mid(load_mid), .step_en(step_en), .step_up(step_up), .done(cal_done)
   );

   icc_strength #(.STR_W(STR_W)) u_str (
      .clk(clk), .rst_n(rst_n), .load_mid(load_mid), .step_en(step_en),
      .step_up(step_up), .rup(rup_code), .rdn(rdn_code)
   );

   icc_leg_drive #(.LEGS(LEGS), .FINE_W(FINE_W)) u_legs (
      .clk(clk), .rst_n(rst_n), .cal_mode(cal_mode), .fine_req(fine_req),
      .load_a_en(load_a_en), .load_b_en(load_b_en)
   );

   // done high after a cycle that already had the mode high means locked
   assert_codes_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && cal_mode && $past(cal_mode)) |=>
         ($stable(rup_code) && $stable(rdn_code) && cal_done));
   assert_codes_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cal_mode && $past(!cal_mode)) |=> ($stable(rup_code) && $stable(rdn_code)));
endmodule

// File: tb/tb_interp_cal_ctrl.sv
`timescale 1ns/1ps
module tb_interp_cal_ctrl;
   localparam int LEGS = 16, STR_W = 5, SETTLE = 3, FINE_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cal_mode = 1'b0, det_late = 1'b0;
   logic [FINE_W-1:0] fine_req = '0;
   logic [STR_W-1:0] rup_code, rdn_code;
   logic [LEGS-1:0] load_a_en, load_b_en;
   logic cal_done;

   interp_cal_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cal_mode(cal_mode), .det_late(det_late),
      .fine_req(fine_req), .rup_code(rup_code), .rdn_code(rdn_code),
      .load_a_en(load_a_en), .load_b_en(load_b_en), .cal_done(cal_done)
   );

   always #2.5 clk = ~clk;

   int checks = 0, failures = 0;
   string cur_tag = "R1";
   bit finished = 1'b0;
   int locks_seen = 0;
   logic [15:0] lfsr = 16'hACE1;

   // behavioural reference model
   int m_st = 0, m_cnt = 0, m_t = 32, m_done = 0, m_have = 0, m_prev = 0, m_tg = 0;
   logic [LEGS-1:0] m_a = '0, m_b = '0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_t = 32; m_done = 0; m_have = 0; m_prev = 0; m_tg = 0;
         m_a = '0; m_b = '0;
      end else begin
         m_a = cal_mode ? '1 : '0;
         m_b = cal_mode ? '0 : LEGS'((1 << fine_req) - 1);
         if (m_st == 0) begin
            if (cal_mode) begin
               m_st = 1; m_done = 0; m_have = 0; m_tg = 0; m_cnt = SETTLE; m_t = 32;
            end
         end else if (m_st == 1) begin
            if (!cal_mode) m_st = 0;
            else if (m_cnt > 0) m_cnt--;
            else begin
               int rev;
               m_cnt = SETTLE;
               rev = (m_have != 0 && int'(det_late) != m_prev) ? 1 : 0;
               m_prev = int'(det_late);
               m_have = 1;
               if (rev != 0 && m_tg != 0) begin
                  m_st = 2; m_done = 1; m_tg = 0; locks_seen++;
               end else begin
                  m_tg = rev;
                  if (det_late) m_t = (m_t < 62) ? m_t + 1 : 62;
                  else          m_t = (m_t > 0) ? m_t - 1 : 0;
               end
            end
         end else begin
            if (!cal_mode) m_st = 0;
         end
      end
      #1;
      chk(cur_tag, "rup_code", int'(rup_code), (m_t + 1) / 2);
      chk(cur_tag, "rdn_code", int'(rdn_code), m_t / 2);
      chk(cur_tag, "cal_done", int'(cal_done), m_done);
      chk((m_a != '0) ? "R2" : cur_tag, "load_a_en", int'(load_a_en), int'(m_a));
      chk((m_a != '0) ? "R2" : cur_tag, "load_b_en", int'(load_b_en), int'(m_b));
   end

   // dm: 0 = constant low, 1 = constant high, 2 = pseudo-random every cycle
   task automatic drive(input int n, input bit mode, input int dm, input int fine);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cal_mode = mode;
         det_late = (dm == 2) ? lfsr[0] : (dm == 1);
         fine_req = FINE_W'(fine);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL R8 watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      cur_tag = "R1";
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cur_tag = "R3";
      for (int f = 0; f < 16; f++) drive(1, 1'b0, 2, f);
      drive(1, 1'b0, 2, 15);
      cur_tag = "R4";
      drive(1, 1'b1, 1, 0);
      cur_tag = "R5";
      drive(3, 1'b1, 2, 0);
      cur_tag = "R6";
      drive(20, 1'b1, 1, 0);
      cur_tag = "R11";
      drive(3, 1'b1, 0, 0);
      cur_tag = "R7";
      drive(160, 1'b1, 1, 5);
      cur_tag = "R10";
      drive(4, 1'b0, 2, 9);
      cur_tag = "R4";
      drive(1, 1'b1, 0, 0);
      cur_tag = "R7";
      drive(160, 1'b1, 0, 0);
      cur_tag = "R8";
      drive(400, 1'b1, 2, 0);
      chk("R8", "lock reached", (locks_seen > 0) ? 1 : 0, 1);
      cur_tag = "R9";
      drive(40, 1'b1, 2, 0);
      cur_tag = "R10";
      drive(6, 1'b0, 2, 7);
      cur_tag = "R3";
      drive(3, 1'b0, 2, 0);
      cur_tag = "R4";
      drive(1, 1'b1, 1, 0);
      cur_tag = "R11";
      drive(30, 1'b1, 2, 0);
      cur_tag = "R10";
      drive(5, 1'b0, 1, 12);
      cur_tag = "R1";
      @(negedge clk);
      rst_n = 1'b0;
      drive(3, 1'b0, 0, 0);
      @(negedge clk);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule